// File: doc/BRIEF.md
# Camera Sensor Register Configuration Master (SCCB)

This block brings an image sensor into a working state after power-up. It walks a stored table of register address and value pairs and writes each pair to the sensor over a two-wire SCCB bus. Before the table it performs one register read, so that the sensor's identity byte can be compared by the surrounding logic. When the last table entry has been written it raises a sticky done flag, and the bus then stays idle.

The block runs from a 25 MHz system clock and derives the serial clock, 100 kHz nominal, by dividing that clock into quarter-bit steps. The data line is open-drain: the block only pulls it low or lets it go, and reads the resolved level back on a separate input. SCCB has no checked acknowledge and no repeated start. The ninth bit of every byte is therefore ignored, and the read is made of two complete transactions with a stop between them. The table contents come from a function of the entry number, and the number of entries is a parameter.

Top module: `sccb_cfg_master`

## Requirements
- R1: While reset is high and after it is released until the first transaction, `scl_o` is 1, `sda_pull_o` is 0, and `cfg_done_o`, `entry_idx_o` and `id_byte_o` are all 0.
- R2: Within a transaction, consecutive rising edges of `scl_o` are 4*QTR_DIV clocks apart, where QTR_DIV = CLK_HZ/(4*SCL_HZ) (62 at defaults, about 100.8 kHz). The data line changes while the clock is high only for a start (falling) or a stop (rising).
- R3: A write transaction is a start, the byte {DEV_ADDR,0}, the register byte and then the value byte, each sent MSB first and each followed by a ninth bit in which the data line is released, and then a stop.
- R4: The level on the ninth bit is never evaluated. Whether the slave holds the line low or leaves it high, the block performs exactly 2+N_ENTRIES transactions with no retry.
- R5: The first transaction writes {DEV_ADDR,0} and ID_REG and ends with a stop. The second is a new start with {DEV_ADDR,1}, followed by 8 data bits received MSB first, then a ninth bit left released (NA, high), then a stop. No repeated start occurs.
- R6: The byte received in the read transaction appears on `id_byte_o` once that transaction ends and is held until reset.
- R7: Table entries are written in index order 0..N_ENTRIES-1. Entry k uses register (3k+1) mod 256 and value (7k+0x3C) mod 256.
- R8: `entry_idx_o` equals the index of the table entry being transferred and reads N_ENTRIES once the table is complete.
- R9: Between a stop and the next start, the bus is idle for at least GAP_BITS*4*QTR_DIV clocks.
- R10: `cfg_done_o` rises only after the stop of the last table entry, stays 1 until reset, and no bus activity follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_o | output | 1 | Serial bus clock |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Resolved level of the data line |
| cfg_done_o | output | 1 | Sticky flag: the whole table has been written |
| id_byte_o | output | 8 | Byte returned by the identity read |
| entry_idx_o | output | $clog2(N_ENTRIES+1) | Index of the current table entry |

## Verification
Two pairs of events share a clock edge. When the final table entry finishes, the end of its transaction, the step of the entry index to N_ENTRIES and the rise of the done flag all happen together. The bench checks that done stays low on every clock until the decoded stop of that last frame, and afterwards that the index reads N_ENTRIES and the bus stays quiet. The second pair is the handoff of the data line between slave and master around the ninth bit and the read byte. The bench's slave pulls the ninth bit low on even frames and leaves it high on odd ones, and drives the identity bits right after SCL falls. Every decoded byte, the NA level and the total frame count are compared with values computed from the requirements.

// File: rtl/sccb_cfg_pkg.sv
package sccb_cfg_pkg;

    // Bus phase of the transaction engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_BITS,
        PH_STOP,
        PH_GAP
    } phase_e;

    // Step of the configuration sequence
    typedef enum logic [1:0] {
        SQ_ID_WR,
        SQ_ID_RD,
        SQ_TABLE,
        SQ_END
    } seq_e;

    // One transaction handed to the engine
    typedef struct packed {
        logic       rd;      // second byte is received, not sent
        logic [1:0] nbytes;  // byte slots in the frame (2 or 3)
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
    } xfer_t;

    // Table content: {register, value} for entry k
    function automatic logic [15:0] cfg_entry(input int k);
        logic [7:0] reg_a;
        logic [7:0] val_d;
        reg_a = 8'(k * 3 + 1);
        val_d = 8'(k * 7 + 8'h3C);
        return {reg_a, val_d};
    endfunction

endpackage

// File: rtl/sccb_qtick.sv
module sccb_qtick #(
    parameter int QTR_DIV = 62
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || tick_o) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == CW'(QTR_DIV - 1));

    generate
        if (QTR_DIV > 1) begin : g_spacing
            // R2: quarter steps never come back to back
            assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/sccb_phy.sv
module sccb_phy
    import sccb_cfg_pkg::*;
#(
    parameter int GAP_BITS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       qtick_i,
    input  logic       go_i,
    input  xfer_t      cmd_i,
    output logic       ready_o,
    output logic       fin_o,
    output logic       scl_o,
    output logic       sda_rel_o,
    input  logic       sda_i,
    output logic [7:0] rd_byte_o
);
    localparam int GAP_Q = (GAP_BITS > 0) ? GAP_BITS * 4 : 1;
    localparam int GW    = $clog2(GAP_Q + 1);

    phase_e        st;
    xfer_t         cmd_q;
    logic [1:0]    q;      // quarter within the current bit
    logic [3:0]    bi;     // slot within the byte, 8 = ninth bit
    logic [1:0]    by;     // byte slot
    logic [GW-1:0] gapc;
    logic          scl_q, sda_q;
    logic [7:0]    rd_sh;
    logic [7:0]    cur_b;
    logic          slot_val;
    logic          last_byte;

    always_comb begin
        case (by)
            2'd0:    cur_b = cmd_q.b0;
            2'd1:    cur_b = cmd_q.b1;
            default: cur_b = cmd_q.b2;
        endcase
        // release on the ninth bit and on every received bit
        slot_val  = (bi == 4'd8) || (cmd_q.rd && by == 2'd1) || cur_b[~bi[2:0]];
        last_byte = (by == cmd_q.nbytes - 2'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PH_IDLE;
            cmd_q <= '0;
            q     <= '0;
            bi    <= '0;
            by    <= '0;
            gapc  <= '0;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            rd_sh <= '0;
            fin_o <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (st == PH_IDLE) begin
                if (go_i) begin
                    cmd_q <= cmd_i;
                    st    <= PH_START;
                    q     <= '0;
                end
            end else if (qtick_i) begin
                q <= q + 2'd1;
                case (st)
                    PH_START: begin
                        if (q == 2'd1) sda_q <= 1'b0;
                        if (q == 2'd3) begin
                            scl_q <= 1'b0;
                            st    <= PH_BITS;
                            bi    <= '0;
                            by    <= '0;
                        end
                    end
                    PH_BITS: begin
                        case (q)
                            2'd0: scl_q <= 1'b0;
                            2'd1: sda_q <= slot_val;
                            2'd2: scl_q <= 1'b1;
                            default: begin
                                if (cmd_q.rd && by == 2'd1 && bi != 4'd8)
                                    rd_sh <= {rd_sh[6:0], sda_i};
                                if (bi == 4'd8) begin
                                    bi <= '0;
                                    if (last_byte) st <= PH_STOP;
                                    else           by <= by + 2'd1;
                                end else begin
                                    bi <= bi + 4'd1;
                                end
                            end
                        endcase
                    end
                    PH_STOP: begin
                        case (q)
                            2'd0: scl_q <= 1'b0;
                            2'd1: sda_q <= 1'b0;
                            2'd2: scl_q <= 1'b1;
                            default: begin
                                sda_q <= 1'b1;
                                st    <= PH_GAP;
                                gapc  <= '0;
                            end
                        endcase
                    end
                    PH_GAP: begin
                        q <= '0;
                        if (gapc == GW'(GAP_Q - 1)) begin
                            st    <= PH_IDLE;
                            fin_o <= 1'b1;
                        end else begin
                            gapc <= gapc + 1'b1;
                        end
                    end
                    default: st <= PH_IDLE;
                endcase
            end
        end
    end

    assign ready_o   = (st == PH_IDLE);
    assign scl_o     = scl_q;
    assign sda_rel_o = sda_q;
    assign rd_byte_o = rd_sh;

    // R2: no data movement while the clock is high inside the bit stream
    assert_sda_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (st == PH_BITS && $past(st) == PH_BITS && scl_q && $past(scl_q)) |-> $stable(sda_q));

    // R4: the ninth bit is always released by the master once it is set up
    assert_ninth_release_R4: assert property (@(posedge clk) disable iff (rst)
        (st == PH_BITS && bi == 4'd8 && q == 2'd2) |-> sda_q);

    // R5: the received byte and its NA bit are never driven low by the master
    assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
        (st == PH_BITS && cmd_q.rd && by == 2'd1 && q == 2'd2) |-> sda_q);
endmodule

// File: rtl/sccb_cfg_master.sv
module sccb_cfg_master
    import sccb_cfg_pkg::*;
#(
    parameter int         CLK_HZ    = 25_000_000,
    parameter int         SCL_HZ    = 100_000,
    parameter int         GAP_BITS  = 2,
    parameter int         N_ENTRIES = 160,
    parameter logic [6:0] DEV_ADDR  = 7'h21,
    parameter logic [7:0] ID_REG    = 8'h0A,
    localparam int        IW        = $clog2(N_ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          scl_o,
    output logic          sda_pull_o,
    input  logic          sda_i,
    output logic          cfg_done_o,
    output logic [7:0]    id_byte_o,
    output logic [IW-1:0] entry_idx_o
);
    localparam int QTR_DIV = CLK_HZ / (4 * SCL_HZ);

    seq_e          seq;
    logic [IW-1:0] idx;
    logic          inflight, done_q;
    logic [7:0]    id_q;
    logic          qtick, ready, fin, go, sda_rel;
    logic [7:0]    rd_byte;
    xfer_t         cmd;

    sccb_qtick #(.QTR_DIV(QTR_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (qtick)
    );

    sccb_phy #(.GAP_BITS(GAP_BITS)) u_phy (
        .clk       (clk),
        .rst       (rst),
        .qtick_i   (qtick),
        .go_i      (go),
        .cmd_i     (cmd),
        .ready_o   (ready),
        .fin_o     (fin),
        .scl_o     (scl_o),
        .sda_rel_o (sda_rel),
        .sda_i     (sda_i),
        .rd_byte_o (rd_byte)
    );

    always_comb begin
        cmd = '0;
        case (seq)
            SQ_ID_WR: begin
                cmd.nbytes = 2'd2;
                cmd.b0     = {DEV_ADDR, 1'b0};
                cmd.b1     = ID_REG;
            end
            SQ_ID_RD: begin
                cmd.rd     = 1'b1;
                cmd.nbytes = 2'd2;
                cmd.b0     = {DEV_ADDR, 1'b1};
            end
            default: begin
                cmd.nbytes         = 2'd3;
                cmd.b0             = {DEV_ADDR, 1'b0};
                {cmd.b1, cmd.b2}   = cfg_entry(int'(idx));
            end
        endcase
    end

    assign go = ready && !inflight && (seq != SQ_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq      <= SQ_ID_WR;
            idx      <= '0;
            inflight <= 1'b0;
            done_q   <= 1'b0;
            id_q     <= '0;
        end else begin
            if (go) inflight <= 1'b1;
            if (fin) begin
                inflight <= 1'b0;
                case (seq)
                    SQ_ID_WR: seq <= SQ_ID_RD;
                    SQ_ID_RD: begin
                        id_q <= rd_byte;
                        seq  <= SQ_TABLE;
                    end
                    SQ_TABLE: begin
                        idx <= idx + 1'b1;
                        if (idx == IW'(N_ENTRIES - 1)) begin
                            seq    <= SQ_END;
                            done_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o  = ~sda_rel;
    assign cfg_done_o  = done_q;
    assign id_byte_o   = id_q;
    assign entry_idx_o = idx;

    // R10: done is sticky
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_done_o |=> cfg_done_o);

    // R10: bus quiet once done
    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_done_o |-> (ready && scl_o && !sda_pull_o));

    // R8: index never runs past the table
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (rst)
        entry_idx_o <= IW'(N_ENTRIES));

    // R6: identity byte frozen once the table phase begins
    assert_id_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (seq inside {SQ_TABLE, SQ_END} && $past(seq inside {SQ_TABLE, SQ_END})) |-> $stable(id_byte_o));
endmodule

// File: tb/tb_sccb_cfg_master.sv
module tb_sccb_cfg_master;
    localparam int         CLK_HZ   = 800;
    localparam int         SCL_HZ   = 100;
    localparam int         QTR      = CLK_HZ / (4 * SCL_HZ);
    localparam int         GAP_BITS = 2;
    localparam int         N        = 6;
    localparam int         TOTAL    = N + 2;
    localparam logic [6:0] DEV      = 7'h21;
    localparam logic [7:0] IDREG    = 8'h0A;
    localparam logic [7:0] SENS_ID  = 8'h76;
    localparam int         IW       = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl, pull, done;
    logic [7:0]    id;
    logic [IW-1:0] idx;
    logic          slave_low = 1'b0;
    wire           sda_line = ~pull & ~slave_low;

    always #2.5 clk = ~clk;

    sccb_cfg_master #(
        .CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .GAP_BITS(GAP_BITS), .N_ENTRIES(N),
        .DEV_ADDR(DEV), .ID_REG(IDREG)
    ) dut (
        .clk(clk), .rst(rst), .scl_o(scl), .sda_pull_o(pull), .sda_i(sda_line),
        .cfg_done_o(done), .id_byte_o(id), .entry_idx_o(idx)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int f);
        return (f < 2) ? 2 : 3;
    endfunction

    function automatic int exp_byte(input int f, input int b);
        int k;
        k = f - 2;
        if (f == 0) return (b == 0) ? {DEV, 1'b0} : IDREG;
        if (f == 1) return (b == 0) ? {DEV, 1'b1} : SENS_ID;
        if (b == 0) return {DEV, 1'b0};
        if (b == 1) return (3 * k + 1) % 256;
        return (7 * k + 8'h3C) % 256;
    endfunction

    // bus decoder and slave model state
    logic       pscl = 1'b1, psda = 1'b1;
    logic [7:0] cur = '0;
    int         bitcnt = 0, frames_done = 0, starts = 0;
    int         cyc = 0, last_rise = -1, last_stop = -1;
    int         byts[$];
    bit         nine[$];
    bit         done_seen = 0;

    task automatic check_frame();
        int f;
        string tag;
        f = frames_done;
        if (f >= TOTAL) begin
            chk(0, "R10 extra frame after table", f, TOTAL - 1);
            return;
        end
        tag = (f < 2) ? "R5 id transaction" : "R7 table write";
        chk(byts.size() == exp_len(f), "R3 frame length", byts.size(), exp_len(f));
        for (int b = 0; b < byts.size() && b < exp_len(f); b++)
            chk(byts[b] == exp_byte(f, b), (b == 0 && f != 1) ? "R3 write address" : tag,
                byts[b], exp_byte(f, b));
        if (f == 1 && nine.size() > 1)
            chk(nine[1] == 1'b1, "R5 NA high", nine[1], 1);
    endtask

    always @(negedge clk) begin
        int pos, bix;
        bit rdf;
        cyc++;
        if (!rst) begin
            if (scl && pscl && psda && !sda_line) begin          // start
                if (last_stop >= 0)
                    chk(cyc - last_stop >= GAP_BITS * 4 * QTR, "R9 idle gap",
                        cyc - last_stop, GAP_BITS * 4 * QTR);
                if (frames_done >= 2)
                    chk(int'(idx) == frames_done - 2, "R8 entry index", idx, frames_done - 2);
                if (frames_done == 2)
                    chk(id == SENS_ID, "R6 id byte", id, SENS_ID);
                bitcnt = 0; byts.delete(); nine.delete(); last_rise = -1; starts++;
            end else if (scl && pscl && !psda && sda_line) begin // stop
                check_frame();
                frames_done++;
                last_stop = cyc;
            end else if (scl && !pscl) begin                     // rising
                if (last_rise >= 0)
                    chk(cyc - last_rise == 4 * QTR, "R2 clock period", cyc - last_rise, 4 * QTR);
                last_rise = cyc;
                pos = bitcnt % 9;
                if (pos < 8) cur = {cur[6:0], sda_line};
                else begin
                    byts.push_back(int'(cur));
                    nine.push_back(sda_line);
                end
                bitcnt++;
            end else if (!scl && pscl) begin                     // falling
                pos = bitcnt % 9;
                bix = bitcnt / 9;
                rdf = (byts.size() > 0) && byts[0][0];
                if (rdf && bix == 1 && pos < 8) slave_low = !SENS_ID[7 - pos];
                else if (pos == 8 && !(rdf && bix == 1)) slave_low = (frames_done % 2 == 0);
                else slave_low = 1'b0;
            end
            if (frames_done < TOTAL) chk(!done, "R10 done before last stop", done, 0);
            if (done_seen) chk(done, "R10 done held", done, 1);
            if (done) done_seen = 1;
        end
        pscl = scl;
        psda = sda_line;
    end

    int wd;
    int s0;

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(scl == 1'b1, "R1 reset scl", scl, 1);
        chk(pull == 1'b0, "R1 reset data released", pull, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(idx == '0, "R1 reset index", idx, 0);
        chk(id == 8'h00, "R1 reset id", id, 0);
        rst = 1'b0;
        wd = 0;
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            chk(0, "R10 watchdog expired", wd, 0);
        end else begin
            repeat (2) @(negedge clk);
            chk(int'(idx) == N, "R8 final index", idx, N);
            chk(id == SENS_ID, "R6 id held", id, SENS_ID);
            chk(frames_done == TOTAL, "R4 no retry frame count", frames_done, TOTAL);
            s0 = starts;
            repeat (1000) @(negedge clk);
            chk(starts == s0, "R10 bus idle after done", starts, s0);
            chk(done == 1'b1, "R10 done still set", done, 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule